// File: doc/BRIEF.md
# Register-mapped serial EEPROM host controller

This block lets a processor drive a word-organized three-wire serial EEPROM (the Microwire style of chip select, serial clock, data out and data in) through a small set of 16-bit registers. Software loads a command word and, for writes, a data word. It then writes a control word whose four request bits ask for a read, a long write, a short command or the turning on of write protection. The controller checks the request, shifts the command word out most significant bit first, and then either shifts 16 bits of read data into a read buffer, sends 16 more bits from the write buffer and waits for the memory's ready signal, or simply drops chip select.

A status word reports whether the engine is idle, whether the last read has finished, and whether protection is on. Protection is sticky. Once it is set, any write or erase aimed at word address 0x30 or higher, and any whole-array write or erase, is dropped without serial traffic.

The controller is a single state machine. Its states are IDLE, CHECK (one cycle that decides whether a request goes on the wire), SEND (command bits, plus data bits for a write), RECV (16 read bits), GAP (chip select low for one half period after a write) and POLL (chip select high until data-in reads 1). Its transitions are: IDLE to CHECK on an accepted request; CHECK to IDLE when blocked, otherwise to SEND; SEND to RECV for a read, to GAP for a write, and to IDLE for a short command; RECV to IDLE after the last bit; GAP to POLL after one half period; POLL to IDLE when the memory reports ready.

Top module: `uw_eeprom_host`

## Requirements
- R1: A write with `reg_sel`=0 stores `reg_wdata` in the command register. `cmd_rdata` reads back exactly that value, and no control operation changes it.
- R2: A write with `reg_sel`=2 carries request bits at bit 4 (read), bit 5 (write), bit 6 (short) and bit 7 (protect). If more than one of the four is set, or none is, the request is ignored: there are no serial clock edges, the controller stays idle, and protection stays off (0x90 does not protect, 0x80 does).
- R3: A read request raises chip select, shifts out the 16 command bits MSB first, then shifts in 16 bits into the read buffer. Status bit 0 reads 0 from the cycle after the request until the read completes, and then reads 1.
- R4: A write request shifts out the 16 command bits and then the 16 write-buffer bits. It then holds chip select low for one half period, raises it again, and stays busy until data-in is sampled high.
- R5: A short request shifts out the 16 command bits, drops chip select and returns to idle.
- R6: A valid protect request sets status bit 7, and no later request clears it before reset.
- R7: The command word has its start bit at bit ADDR_W+2, its opcode at bits ADDR_W+1..ADDR_W (01 write, 10 read, 11 erase, 00 extended) and the word address at bits ADDR_W-1..0. For the extended opcode, the sub-code is the top two address bits (00 disable, 01 write all, 10 erase all, 11 enable). While protection is on, a write or short request whose command is a write or erase at an address of PROT_BASE or higher, or a write-all or erase-all, produces no serial traffic. Status bit 1 reads 0 for exactly one cycle and then 1.
- R8: The write-buffer value is captured when a write starts. Changing the buffer afterwards does not change the data that is sent.
- R9: The read buffer changes only when a read completes. Writes to the write buffer and non-read requests change neither the read buffer nor status bit 0.
- R10: Each half period of the serial clock lasts SK_HALF system clocks. Data-out changes only while the serial clock is low. The serial clock is high only while chip select is high.
- R11: A control write that arrives while the controller is busy is ignored.
- R12: Status bit 1 is 1 when idle and 0 when busy. After reset, status reads 0x0003, the command register and read buffer read 0, and chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target: 0 command, 1 write buffer, 2 control, 3 unused |
| reg_wdata | input | DATA_W | Register write data |
| cmd_rdata | output | DATA_W | Command register readback |
| rdata | output | DATA_W | Read buffer |
| status | output | DATA_W | Bit 0 read done, bit 1 idle, bit 7 protection on |
| mw_cs | output | 1 | Serial chip select |
| mw_sk | output | 1 | Serial clock |
| mw_do | output | 1 | Serial data to the memory |
| mw_di | input | 1 | Serial data and ready from the memory |

## Verification
A state machine stuck in the wrong state shows within one serial half period: either status bit 1 disagrees with chip select, or serial clock edges appear when none are due. A bad shift or bit count shows as a wrong command or data word captured by the bench's memory model once chip select falls, or as a wrong read buffer value on the cycle the read completes. A broken protect or validity decode shows on status bit 7 on the cycle after the control write, or as a blocked request that still drives the serial clock.

// File: rtl/uw_pkg.sv
package uw_pkg;
    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_SH = 2'd2
    } uw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEND,
        ST_RECV,
        ST_GAP,
        ST_POLL
    } uw_state_e;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_WBUF = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int REQ_LSB = 4;
endpackage

// File: rtl/uw_req_check.sv
module uw_req_check
    import uw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PROT_BASE = 48
) (
    input  logic [3:0]        req,
    input  logic [ADDR_W+1:0] cmd_lo,
    input  logic              prot,
    output logic              go,
    output uw_op_e            op,
    output logic              set_prot,
    output logic              blocked
);
    localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_BASE);

    logic [ADDR_W-1:0] addr;
    logic [1:0]        opc;
    logic [1:0]        sub;
    logic              single;
    logic              hits_high;

    always_comb begin
        addr      = cmd_lo[ADDR_W-1:0];
        opc       = cmd_lo[ADDR_W+1:ADDR_W];
        sub       = cmd_lo[ADDR_W-1:ADDR_W-2];
        single    = ($countones(req) == 1);
        go        = single && !req[3];
        set_prot  = single && req[3];
        if (req[0])
            op = OP_RD;
        else if (req[1])
            op = OP_WR;
        else
            op = OP_SH;
        hits_high = ((opc == 2'b01 || opc == 2'b11) && (addr >= PROT_A)) ||
                    ((opc == 2'b00) && (sub == 2'b01 || sub == 2'b10));
        blocked   = prot && (op != OP_RD) && hits_high;
    end
endmodule

// File: rtl/uw_serial_engine.sv
module uw_serial_engine
    import uw_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  uw_op_e            op,
    input  logic              blocked,
    input  logic [DATA_W-1:0] cmd_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              mw_di,
    output logic              busy,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_do,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word
);
    localparam int SR_W  = 2 * DATA_W;
    localparam int CNT_W = $clog2(SR_W);
    localparam int DIV_W = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;

    uw_state_e         state, nxt;
    uw_op_e            op_q;
    logic              blk_q;
    logic [SR_W-1:0]   out_sr;
    logic [DATA_W-1:0] in_sr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [DIV_W-1:0]  div_cnt;
    logic              ph;
    logic              tick;
    logic              out_last;
    logic              in_last;

    always_comb begin
        tick     = (div_cnt == DIV_W'(SK_HALF - 1));
        last_idx = (op_q == OP_WR) ? CNT_W'(SR_W - 1) : CNT_W'(DATA_W - 1);
        out_last = (cnt == last_idx);
        in_last  = (cnt == CNT_W'(DATA_W - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CHECK;
            ST_CHECK: nxt = blk_q ? ST_IDLE : ST_SEND;
            ST_SEND:  if (tick && ph && out_last)
                          nxt = (op_q == OP_RD) ? ST_RECV :
                                (op_q == OP_WR) ? ST_GAP  : ST_IDLE;
            ST_RECV:  if (tick && ph && in_last) nxt = ST_IDLE;
            ST_GAP:   if (tick) nxt = ST_POLL;
            ST_POLL:  if (tick && mw_di) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath: divider, phase, shift registers, bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_SH;
            blk_q   <= 1'b0;
            out_sr  <= '0;
            in_sr   <= '0;
            cnt     <= '0;
            div_cnt <= '0;
            ph      <= 1'b0;
        end else begin
            if (state == ST_IDLE || state == ST_CHECK || tick)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;

            unique case (state)
                ST_IDLE: begin
                    ph  <= 1'b0;
                    cnt <= '0;
                    if (start) begin
                        op_q   <= op;
                        blk_q  <= blocked;
                        out_sr <= {cmd_in, wdata_in};
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (!ph) begin
                            ph <= 1'b1;
                        end else begin
                            ph     <= 1'b0;
                            out_sr <= {out_sr[SR_W-2:0], 1'b0};
                            cnt    <= out_last ? '0 : cnt + 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (!ph) begin
                            ph    <= 1'b1;
                            in_sr <= {in_sr[DATA_W-2:0], mw_di};
                        end else begin
                            ph  <= 1'b0;
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: ph <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        mw_cs    = (state == ST_SEND) || (state == ST_RECV) || (state == ST_POLL);
        mw_sk    = ph && ((state == ST_SEND) || (state == ST_RECV));
        mw_do    = (state == ST_SEND) && out_sr[SR_W-1];
        rd_valid = (state == ST_RECV) && tick && ph && in_last;
        rd_word  = in_sr;
    end
endmodule

// File: rtl/uw_eeprom_host.sv
module uw_eeprom_host
    import uw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int SK_HALF   = 4,
    parameter int PROT_BASE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] status,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_do,
    input  logic              mw_di
);
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              prot_q;
    logic              rd_done_q;
    logic              busy;
    logic              go;
    logic              set_prot;
    logic              blocked;
    uw_op_e            op;
    logic              ctrl_fire;
    logic              start;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_word;

    uw_req_check #(
        .ADDR_W   (ADDR_W),
        .PROT_BASE(PROT_BASE)
    ) u_check (
        .req     (reg_wdata[REQ_LSB+3:REQ_LSB]),
        .cmd_lo  (cmd_q[ADDR_W+1:0]),
        .prot    (prot_q),
        .go      (go),
        .op      (op),
        .set_prot(set_prot),
        .blocked (blocked)
    );

    always_comb begin
        ctrl_fire = reg_we && (reg_sel == SEL_CTRL) && !busy;
        start     = ctrl_fire && go;
    end

    uw_serial_engine #(
        .DATA_W (DATA_W),
        .SK_HALF(SK_HALF)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .blocked (blocked),
        .cmd_in  (cmd_q),
        .wdata_in(wbuf_q),
        .mw_di   (mw_di),
        .busy    (busy),
        .mw_cs   (mw_cs),
        .mw_sk   (mw_sk),
        .mw_do   (mw_do),
        .rd_valid(rd_valid),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            wbuf_q    <= '0;
            rbuf_q    <= '0;
            prot_q    <= 1'b0;
            rd_done_q <= 1'b1;
        end else begin
            if (reg_we && reg_sel == SEL_CMD)
                cmd_q <= reg_wdata;
            if (reg_we && reg_sel == SEL_WBUF)
                wbuf_q <= reg_wdata;
            if (ctrl_fire && set_prot)
                prot_q <= 1'b1;
            if (rd_valid) begin
                rbuf_q    <= rd_word;
                rd_done_q <= 1'b1;
            end else if (start && op == OP_RD) begin
                rd_done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cmd_rdata = cmd_q;
        rdata     = rbuf_q;
        status    = {{(DATA_W-8){1'b0}}, prot_q, 5'b0, ~busy, rd_done_q};
    end
endmodule

// File: rtl/uw_eeprom_host_chk.sv
module uw_eeprom_host_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] cmd_rdata,
    input logic [DATA_W-1:0] rdata,
    input logic              st_rd,
    input logic              st_idle,
    input logic              st_prot,
    input logic              mw_cs,
    input logic              mw_sk
);
    // R10: serial clock only pulses inside a chip-select window
    p_sk_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> mw_cs);

    // R12: idle status never coexists with an active chip select
    p_idle_no_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !mw_cs);

    // R6: protection never falls once raised
    p_prot_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_prot |=> st_prot);

    // R9: read buffer moves only on the cycle a read completes
    p_rbuf_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (st_rd && !$past(st_rd)));

    // R1: command register changes only by a command write, to the written value
    p_cmd_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_rdata) |-> ($past(reg_we) && $past(reg_sel) == 2'd0 &&
                                 cmd_rdata == $past(reg_wdata)));

    // R2: a multi-bit request leaves the block idle and protection unchanged
    p_invalid_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd2 && st_idle && $countones(reg_wdata[7:4]) > 1)
        |=> (st_idle && st_prot == $past(st_prot)));
endmodule

bind uw_eeprom_host uw_eeprom_host_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .cmd_rdata(cmd_rdata),
    .rdata    (rdata),
    .st_rd    (status[0]),
    .st_idle  (status[1]),
    .st_prot  (status[7]),
    .mw_cs    (mw_cs),
    .mw_sk    (mw_sk)
);

// File: tb/uw_eeprom_host_tb_top.sv
`timescale 1ns/100ps
module uw_eeprom_host_tb_top;
    localparam int SK_HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] cmd_rdata, rdata, status;
    logic        mw_cs, mw_sk, mw_do;
    logic        mw_di = 1'b1;

    always #2.5 clk = ~clk;

    uw_eeprom_host #(.ADDR_W(10), .DATA_W(16), .SK_HALF(SK_HALF), .PROT_BASE(48)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .rdata(rdata),
        .status(status), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .mw_di(mw_di)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [15:0] exp_cmd = 16'h0;
    logic        exp_prot = 1'b0;

    // memory model state
    logic [15:0] mem [0:1023];
    logic        wen = 1'b0;
    logic [15:0] cap_cmd = 16'h0;
    logic [15:0] cap_data = 16'h0;
    int nb = 0;
    int last_bits = 0;
    int rises = 0;
    int busy_cnt = 0;
    int cyc = 0;
    int last_rise = -1;
    int period = 0;
    int do_viol = 0;
    logic prev_sk = 1'b0, prev_cs = 1'b0, prev_do = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural serial memory, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (mw_cs && !prev_cs) begin
            nb = 0;
            last_rise = -1;
        end
        if (mw_cs && mw_sk && !prev_sk) begin
            rises++;
            if (last_rise >= 0) period = cyc - last_rise;
            last_rise = cyc;
            if (nb < 16) cap_cmd = {cap_cmd[14:0], mw_do};
            else if (cap_cmd[11:10] != 2'b10) cap_data = {cap_data[14:0], mw_do};
            nb++;
        end
        if (mw_cs && mw_sk && prev_sk && mw_do != prev_do) do_viol++;
        if (mw_cs && !mw_sk && prev_sk && cap_cmd[11:10] == 2'b10 && nb >= 16 && nb < 32)
            mw_di = mem[cap_cmd[9:0]][31-nb];
        if (!mw_cs && prev_cs) begin
            if (nb == 32 && cap_cmd[11:10] == 2'b01) begin
                if (wen) mem[cap_cmd[9:0]] = cap_data;
                busy_cnt = 10; mw_di = 1'b0; last_bits = nb;
            end else if (nb == 32 && cap_cmd[11:8] == 4'b0001) begin
                if (wen) for (int i = 0; i < 1024; i++) mem[i] = cap_data;
                busy_cnt = 10; mw_di = 1'b0; last_bits = nb;
            end else if (nb == 16 && cap_cmd[11:10] == 2'b11) begin
                if (wen) mem[cap_cmd[9:0]] = 16'hFFFF;
                last_bits = nb;
            end else if (nb == 16 && cap_cmd[11:10] == 2'b00) begin
                if (cap_cmd[9:8] == 2'b00) wen = 1'b0;
                if (cap_cmd[9:8] == 2'b11) wen = 1'b1;
                if (cap_cmd[9:8] == 2'b10 && wen) for (int i = 0; i < 1024; i++) mem[i] = 16'hFFFF;
                last_bits = nb;
            end else if (nb > 0) begin
                last_bits = nb;
            end
            nb = 0;
        end
        if (mw_cs && busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) mw_di = 1'b1;
        end
        prev_sk = mw_sk; prev_cs = mw_cs; prev_do = mw_do;
    end

    // per-clock comparison against the reference model
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            check(cmd_rdata == exp_cmd, "R1 cmd per-clock", cmd_rdata, exp_cmd);
            check(status[7] == exp_prot, "R6 prot per-clock", {15'b0, status[7]}, {15'b0, exp_prot});
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d, input bit idle_now);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        if (sel == 2'd0) exp_cmd = d;
        if (sel == 2'd2 && d[7:4] == 4'b1000 && idle_now) exp_prot = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (status[1] == 1'b0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 16'h0003, "R12 reset status", status, 16'h0003);
        check(cmd_rdata == 16'h0, "R12 reset cmd", cmd_rdata, 16'h0);
        check(rdata == 16'h0, "R12 reset rdata", rdata, 16'h0);
        check(mw_cs == 1'b0, "R12 reset cs", {15'b0, mw_cs}, 16'h0);

        // R1 / R5: enable command as a short request
        reg_write(2'd0, 16'h1300, 1);
        check(cmd_rdata == 16'h1300, "R1 readback", cmd_rdata, 16'h1300);
        reg_write(2'd2, 16'h0040, 1);
        check(status[1] == 1'b0, "R12 busy after start", status, 16'h0001);
        wait_idle();
        @(negedge clk);
        check(last_bits == 16, "R5 short bit count", 16'(last_bits), 16'd16);
        check(cap_cmd == 16'h1300, "R5 short cmd bits", cap_cmd, 16'h1300);
        check(wen == 1'b1, "R5 enable seen", {15'b0, wen}, 16'h1);
        check(cmd_rdata == 16'h1300, "R1 cmd untouched by op", cmd_rdata, 16'h1300);

        // R4 / R8: write word 5, buffer changed after start
        reg_write(2'd0, 16'h1405, 1);
        reg_write(2'd1, 16'hBEEF, 1);
        reg_write(2'd2, 16'h0020, 1);
        reg_write(2'd1, 16'h1234, 0);
        wait_idle();
        @(negedge clk);
        check(last_bits == 32, "R4 write bit count", 16'(last_bits), 16'd32);
        check(mem[5] == 16'hBEEF, "R8 captured write data", mem[5], 16'hBEEF);
        check(period == 2 * SK_HALF, "R10 sk period", 16'(period), 16'(2 * SK_HALF));

        // R3: read word 5
        reg_write(2'd0, 16'h1805, 1);
        reg_write(2'd2, 16'h0010, 1);
        check(status[0] == 1'b0, "R3 done cleared", status, 16'h0000);
        wait_idle();
        check(rdata == 16'hBEEF, "R3 read data", rdata, 16'hBEEF);
        check(status[0] == 1'b1, "R3 done set", status, 16'h0001);

        // R9: wbuf write plus erase leave read side alone
        reg_write(2'd1, 16'h5555, 1);
        reg_write(2'd0, 16'h1C06, 1);
        mem[6] = 16'h0123;
        reg_write(2'd2, 16'h0040, 1);
        wait_idle();
        @(negedge clk);
        check(rdata == 16'hBEEF, "R9 rdata kept", rdata, 16'hBEEF);
        check(status[0] == 1'b1, "R9 done kept", status, 16'h0001);
        check(mem[6] == 16'hFFFF, "R5 erase done", mem[6], 16'hFFFF);

        // R2: invalid multi-bit requests
        snap = rises;
        reg_write(2'd2, 16'h0090, 1);
        check(status[1] == 1'b1, "R2 stays idle", status, 16'h0002);
        check(status[7] == 1'b0, "R2 0x90 no protect", status, 16'h0000);
        reg_write(2'd2, 16'h0030, 1);
        repeat (20) @(negedge clk);
        check(rises == snap, "R2 no serial traffic", 16'(rises), 16'(snap));

        // R6: protect and stickiness
        reg_write(2'd2, 16'h0080, 1);
        check(status[7] == 1'b1, "R6 protect set", status, 16'h0080);
        reg_write(2'd2, 16'h0000, 1);
        check(status[7] == 1'b1, "R6 protect sticky", status, 16'h0080);

        // R7: blocked write at 0x30
        snap = rises;
        reg_write(2'd0, 16'h1430, 1);
        reg_write(2'd1, 16'hAAAA, 1);
        reg_write(2'd2, 16'h0020, 1);
        check(status[1] == 1'b0, "R7 one busy cycle", status, 16'h0080);
        @(negedge clk);
        check(status[1] == 1'b1, "R7 back to idle", status, 16'h0082);
        repeat (20) @(negedge clk);
        check(rises == snap, "R7 no traffic", 16'(rises), 16'(snap));
        check(mem[48] == 16'h0000, "R7 high word kept", mem[48], 16'h0000);
        reg_write(2'd0, 16'h1200, 1);
        reg_write(2'd2, 16'h0040, 1);
        repeat (20) @(negedge clk);
        check(rises == snap, "R7 erase-all blocked", 16'(rises), 16'(snap));
        reg_write(2'd0, 16'h142F, 1);
        reg_write(2'd2, 16'h0020, 1);
        wait_idle();
        @(negedge clk);
        check(mem[47] == 16'hAAAA, "R7 low word writable", mem[47], 16'hAAAA);

        // R11: control write while busy is dropped
        reg_write(2'd0, 16'h182F, 1);
        snap = rises;
        reg_write(2'd2, 16'h0010, 1);
        repeat (10) @(negedge clk);
        reg_write(2'd2, 16'h0040, 0);
        wait_idle();
        repeat (50) @(negedge clk);
        check(rises == snap + 32, "R11 busy write ignored", 16'(rises), 16'(snap + 32));
        check(rdata == 16'hAAAA, "R3 second read", rdata, 16'hAAAA);
        check(do_viol == 0, "R10 do stable while sk high", 16'(do_viol), 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule